// File: doc/BRIEF.md
# Single-Port RAM FIFO Controller

This block is a first-in-first-out queue whose storage is a single-port RAM. The RAM has a write data port and a read data port but only one address bus and one active-high write enable. So the controller keeps a write pointer and a read pointer and puts exactly one of them on the shared address bus each cycle. An accepted write takes the bus for its cycle. In every other cycle the read pointer holds the bus, so the read port shows the oldest stored word.

Both data sides use a valid/ready stream interface:

- **Write side.** A word is taken on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is low when the queue is full. It is also low when a pop is being served in the same cycle, because the address bus is then busy.
- **Read side.** `out_valid` is high whenever the queue holds a word. The head word is consumed on a rising edge when `out_ready` is high.
- **Data stability.** `out_data` is guaranteed in every cycle where no write is accepted. Pops take priority, so every completed read handshake sees the correct head word.

An upstream source that holds `in_valid` against a low `in_ready` is told so by the registered `nopush` pulse. A consumer that asks while the queue is empty is told so by `nopop`.

The synchronous `init` input clears the queue. The `full` and `empty` flags are derived from an occupancy count.

Top module: `sp_fifo`

## Requirements
- R1: In the cycle after `init` is sampled high, `empty`=1, `full`=0, `nopush`=0, `nopop`=0 and `out_valid`=0. While `init` is high, no write is accepted and no pop is served.
- R2: Words leave in the order they were written. In a cycle with no accepted write and a non-empty queue, `out_data` equals the oldest stored word.
- R3: `full` is 1 exactly when DEPTH (8) words are stored. A write attempted while full is not stored, changes no pointer, and makes `nopush` high for the following cycle only.
- R4: `empty` is 1 exactly when no word is stored. A pop attempted while empty changes nothing, and makes `nopop` high for the following cycle only.
- R5: When `in_valid` and `out_ready` are both high and the queue is not empty, the pop is served and the write is refused: `mem_we`=0, and `nopush`=1 in the next cycle.
- R6: When `in_valid` and `out_ready` are both high and the queue is empty, the write is served and `nopop`=1 in the next cycle.
- R7: `mem_we` is 1 only in a cycle where a write is accepted (`in_valid` and `in_ready` high, `init` low). In that cycle `mem_addr` carries the write pointer.
- R8: In cycles without an accepted write, `mem_addr` carries the read pointer. Both pointers start at 0, step by one per accepted operation, and wrap from DEPTH-1 (7) to 0.
- R9: `in_ready` = not full and not (`out_ready` and not empty). `out_valid` = not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| init | input | 1 | Synchronous clear, active high |
| in_valid | input | 1 | Write request (push) |
| in_ready | output | 1 | Write can be taken this cycle |
| in_data | input | DATA_W (4) | Word to store |
| out_valid | output | 1 | Queue holds at least one word |
| out_ready | input | 1 | Read request (pop) |
| out_data | output | DATA_W (4) | RAM read port, head word |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No word stored |
| nopush | output | 1 | Previous cycle refused a write request |
| nopop | output | 1 | Previous cycle refused a read request |
| mem_addr | output | ADDR_W (3) | Shared RAM address bus |
| mem_we | output | 1 | RAM write enable |

## Verification
The properties assume that `init` is high from time zero through the first rising edge, so that the pointers and the count are defined before any property is evaluated. They also assume that every input is a clean 0 or 1 at each edge. The bench holds `init` high from the start and drives all inputs on falling edges, always with known values. It then sweeps every pairing of write and read requests across empty, partly filled and full states. This sweep includes pointer wrap-around and an `init` applied in the middle of traffic.

// File: rtl/spfifo_pkg.sv
package spfifo_pkg;

  // Which pointer owns the shared address bus this cycle.
  typedef enum logic {
    BUS_RD = 1'b0,
    BUS_WR = 1'b1
  } bus_owner_e;

  // Per-cycle decision of the arbiter.
  typedef struct packed {
    logic push_take;
    logic pop_take;
    logic push_rej;
    logic pop_rej;
  } grant_t;

endpackage

// File: rtl/spfifo_arbiter.sv
module spfifo_arbiter
  import spfifo_pkg::*;
(
  input  logic       init,
  input  logic       in_valid,
  input  logic       out_ready,
  input  logic       full,
  input  logic       empty,
  output grant_t     gnt,
  output bus_owner_e owner,
  output logic       in_ready
);

  logic pop_ok;
  logic push_ok;

  // A pop wins the single address bus whenever it can be served.
  assign pop_ok   = out_ready && !empty;
  assign push_ok  = !full && !pop_ok;
  assign in_ready = push_ok;

  always_comb begin
    gnt           = '0;
    gnt.pop_take  = !init && pop_ok;
    gnt.push_take = !init && in_valid && push_ok;
    gnt.pop_rej   = !init && out_ready && !pop_ok;
    gnt.push_rej  = !init && in_valid && !push_ok;
  end

  assign owner = gnt.push_take ? BUS_WR : BUS_RD;

endmodule

// File: rtl/spfifo_ptrs.sv
module spfifo_ptrs #(
  parameter int DEPTH = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              init,
  input  logic              push_take,
  input  logic              pop_take,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] rptr,
  output logic              full,
  output logic              empty
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (init) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_take) begin
        wptr  <= bump(wptr);
        count <= count + 1'b1;
      end else if (pop_take) begin
        rptr  <= bump(rptr);
        count <= count - 1'b1;
      end
    end
  end

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

endmodule

// File: rtl/spfifo_ram.sv
module spfifo_ram #(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/spfifo_flags.sv
module spfifo_flags (
  input  logic clk,
  input  logic init,
  input  logic push_rej,
  input  logic pop_rej,
  output logic nopush,
  output logic nopop
);

  always_ff @(posedge clk) begin
    if (init) begin
      nopush <= 1'b0;
      nopop  <= 1'b0;
    end else begin
      nopush <= push_rej;
      nopop  <= pop_rej;
    end
  end

endmodule

// File: rtl/sp_fifo.sv
module sp_fifo
  import spfifo_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              init,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              full,
  output logic              empty,
  output logic              nopush,
  output logic              nopop,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we
);

  grant_t            gnt;
  bus_owner_e        owner;
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W-1:0] rptr;

  spfifo_arbiter u_arb (
    .init      (init),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .full      (full),
    .empty     (empty),
    .gnt       (gnt),
    .owner     (owner),
    .in_ready  (in_ready)
  );

  spfifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .init      (init),
    .push_take (gnt.push_take),
    .pop_take  (gnt.pop_take),
    .wptr      (wptr),
    .rptr      (rptr),
    .full      (full),
    .empty     (empty)
  );

  // Shared address bus: one pointer at a time.
  always_comb begin
    unique case (owner)
      BUS_WR:  mem_addr = wptr;
      default: mem_addr = rptr;
    endcase
  end

  assign mem_we    = gnt.push_take;
  assign out_valid = !empty;

  spfifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (in_data),
    .rdata (out_data)
  );

  spfifo_flags u_flags (
    .clk      (clk),
    .init     (init),
    .push_rej (gnt.push_rej),
    .pop_rej  (gnt.pop_rej),
    .nopush   (nopush),
    .nopop    (nopop)
  );

endmodule

// File: rtl/spfifo_checker.sv
module spfifo_checker (
  input logic clk,
  input logic init,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic full,
  input logic empty,
  input logic nopush,
  input logic nopop,
  input logic mem_we
);

  a_r1_init_clears: assert property (@(posedge clk) disable iff (init)
    $past(init) |-> (empty && !full && !nopush && !nopop && !out_valid));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (init)
    full |-> !mem_we);

  a_r3_full_push_flag: assert property (@(posedge clk) disable iff (init)
    (full && in_valid && !out_ready) |=> (nopush && full));

  a_r4_empty_pop_flag: assert property (@(posedge clk) disable iff (init)
    (empty && out_ready && !in_valid) |=> (nopop && empty));

  a_r5_pop_wins: assert property (@(posedge clk) disable iff (init)
    (in_valid && out_ready && !empty) |-> !mem_we);

  a_r5_push_refused: assert property (@(posedge clk) disable iff (init)
    (in_valid && out_ready && !empty) |=> nopush);

  a_r6_empty_push_wins: assert property (@(posedge clk) disable iff (init)
    (empty && in_valid && out_ready) |=> (nopop && !empty));

  a_r7_we_only_on_handshake: assert property (@(posedge clk) disable iff (init)
    mem_we |-> (in_valid && in_ready));

  a_r9_ready_not_full: assert property (@(posedge clk) disable iff (init)
    in_ready |-> !full);

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (init)
    !(full && empty));

endmodule

bind sp_fifo spfifo_checker u_chk (
  .clk       (clk),
  .init      (init),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .full      (full),
  .empty     (empty),
  .nopush    (nopush),
  .nopop     (nopop),
  .mem_we    (mem_we)
);

// File: tb/tb_sp_fifo.sv
module tb_sp_fifo;
  localparam int DW    = 4;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          init = 1'b1;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, full, empty, nopush, nopop, mem_we;
  logic [DW-1:0] out_data;
  logic [AW-1:0] mem_addr;

  sp_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .init(init), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .full(full), .empty(empty), .nopush(nopush),
    .nopop(nopop), .mem_addr(mem_addr), .mem_we(mem_we)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [DW-1:0] mq [DEPTH];
  int  wp, rp, cnt;
  bit  e_nopush, e_nopop;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, check before the rising edge,
  // then advance the model.
  task automatic cyc(input bit v, input bit r, input logic [DW-1:0] d);
    bit pop_t, push_t;
    init = 1'b0; in_valid = v; out_ready = r; in_data = d;
    #1;
    pop_t  = r && (cnt != 0);
    push_t = v && (cnt != DEPTH) && !pop_t;
    chk("R9", "in_ready", 32'(in_ready), 32'((cnt != DEPTH) && !(r && cnt != 0)));
    chk("R9", "out_valid", 32'(out_valid), 32'(cnt != 0));
    chk("R7", "mem_we", 32'(mem_we), 32'(push_t));
    chk("R8", "mem_addr", 32'(mem_addr), 32'(push_t ? wp : rp));
    chk("R3", "full", 32'(full), 32'(cnt == DEPTH));
    chk("R4", "empty", 32'(empty), 32'(cnt == 0));
    chk("R5", "nopush", 32'(nopush), 32'(e_nopush));
    chk("R6", "nopop", 32'(nopop), 32'(e_nopop));
    if (!push_t && cnt != 0) chk("R2", "out_data", 32'(out_data), 32'(mq[rp]));
    @(posedge clk);
    if (push_t) begin mq[wp] = d; wp = (wp + 1) % DEPTH; cnt++; end
    if (pop_t)  begin rp = (rp + 1) % DEPTH; cnt--; end
    e_nopush = v && !push_t;
    e_nopop  = r && !pop_t;
    @(negedge clk);
  endtask

  // Apply init with requests high: they must be ignored (R1).
  task automatic do_init();
    init = 1'b1; in_valid = 1'b1; out_ready = 1'b1; in_data = 4'hF;
    @(posedge clk);
    wp = 0; rp = 0; cnt = 0; e_nopush = 0; e_nopop = 0;
    @(negedge clk);
    init = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk("R1", "empty", 32'(empty), 32'd1);
    chk("R1", "full", 32'(full), 32'd0);
    chk("R1", "nopush", 32'(nopush), 32'd0);
    chk("R1", "nopop", 32'(nopop), 32'd0);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_init();
    // R2/R3: fill, then overflow attempt
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, DW'(i + 3));
    cyc(1'b1, 1'b0, 4'hF);          // R3 refused write
    cyc(1'b0, 1'b0, 4'h0);
    cyc(1'b1, 1'b1, 4'h9);          // R5 pop wins
    while (cnt > 0) cyc(1'b0, 1'b1, 4'h0);
    cyc(1'b0, 1'b1, 4'h0);          // R4 pop on empty
    cyc(1'b1, 1'b1, 4'h6);          // R6 push wins on empty
    cyc(1'b0, 1'b0, 4'h0);
    // Sweep request patterns; model wraps pointers (R8)
    for (int mode = 0; mode < 4; mode++) begin
      for (int k = 0; k < 1500; k++) begin
        bit v, r;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (mode)
          0: begin v = lf[0]; r = lf[1]; end
          1: begin v = (lf[1:0] != 2'b00); r = (lf[3:2] == 2'b00); end
          2: begin v = (lf[1:0] == 2'b00); r = (lf[3:2] != 2'b00); end
          default: begin v = k[0]; r = k[1]; end
        endcase
        if (mode == 2 && k == 700) do_init();   // R1 mid-traffic
        cyc(v, r, lf[7:4]);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule